// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a single port of up to 32 general-purpose pins attached to a simple 32-bit register bus. Software makes pins outputs or inputs and sets or clears the driven values. Each of these actions uses a write-one register, so one write never needs a read first. The port samples every input through a synchronizer, and software can read the synchronized value at any time.

The lowest eight pins can also raise interrupts. A control word chooses the trigger for each of these pins. It has a level-select lane, a high-or-rising lane, a low-or-falling lane and a debounce lane. Combining these bits gives rising-edge, falling-edge, either-edge, active-high or active-low triggering. If neither direction bit is set, the pin is masked. Each pin that fires sets a pending bit. Software clears a pending bit by writing one to it. The block ORs all pending bits into a single interrupt line.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` zero), `pin_o` is zero, the control word is zero, no interrupt is pending and `irq_o` is low.
- R2: A write to 0x14 turns the pins whose data bits are 1 into outputs. A write to 0x18 turns such pins into inputs. Reading 0x10 returns the direction, with 1 meaning output, and `pin_oe` follows the same value.
- R3: A write to 0x08 sets the output latch bits whose data bits are 1, and a write to 0x0C clears them. Reading 0x04 returns the latch, and `pin_o` drives it.
- R4: Reading 0x00 returns the pins after a two-flop synchronizer. A pin change set up before clock edge k is still not visible after edge k and is visible after edge k+1.
- R5: The control word has four lanes. Bits 7:0 select level mode (1 = level, 0 = edge). Bits 15:8 enable high or rising. Bits 23:16 enable low or falling. Bits 31:24 enable debounce. A write to 0x20 sets the bits that are 1 in the data, a write to 0x24 clears them, and 0x1C reads the word back.
- R6: In edge mode, the high bit alone triggers on a rising edge, the low bit alone on a falling edge, and both bits on either edge.
- R7: In level mode, the high bit triggers while the pin is 1, and the low bit triggers while the pin is 0.
- R8: A pin whose high and low bits are both clear never becomes pending.
- R9: Pins 8 and up never interrupt, and bits 31:8 of the status register at 0x28 always read 0.
- R10: An edge-mode pending bit stays set until a 1 is written to its bit at 0x2C. The write clears it.
- R11: A level-mode pending bit is still set after an acknowledge if its active level is still present.
- R12: If an edge is detected in the same cycle as an acknowledge of that pin, the edge wins and the pending bit stays set.
- R13: With debounce enabled, a pin change is accepted only after it has been stable for `DEBOUNCE_CYCLES` cycles (default 16). Shorter pulses are ignored.
- R14: `irq_o` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational from `addr` while `rd_en` is high, else zero |
| pin_i | input | NPINS | Raw pin inputs |
| pin_o | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enable per pin, 1 = output |
| irq_o | output | 1 | Combined interrupt |

## Verification
A corrupted pending or previous-sample flop shows up in the status register and on `irq_o` within two or three cycles of the pin change that should have set it. The bench reads status after every step of a trigger sweep for each interrupt pin and each of the five modes. An acknowledge that lands one cycle off the edge detection flips the outcome of the race check, so a pipeline of the wrong depth is caught there. A debounce counter that is off by a few cycles either lets a short pulse through or holds back a long one, and the next status read shows it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned LANE_W  = 8;

   // register word index (byte address bits [5:2])
   typedef enum logic [3:0] {
      REG_PIN      = 4'd0,
      REG_OUT      = 4'd1,
      REG_OUT_SET  = 4'd2,
      REG_OUT_CLR  = 4'd3,
      REG_DIR      = 4'd4,
      REG_DIR_OUT  = 4'd5,
      REG_DIR_IN   = 4'd6,
      REG_CTRL     = 4'd7,
      REG_CTRL_SET = 4'd8,
      REG_CTRL_CLR = 4'd9,
      REG_STAT     = 4'd10,
      REG_ACK      = 4'd11
   } reg_idx_e;

   // trigger control word, one 8-bit lane per function
   typedef struct packed {
      logic [LANE_W-1:0] dbnc;
      logic [LANE_W-1:0] low;
      logic [LANE_W-1:0] high;
      logic [LANE_W-1:0] lvl;
   } trig_ctrl_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
      end else begin
         st_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      end
   end

   assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic d_i,
   output logic q_o
);
   localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   if (CYCLES < 1) begin : g_bad
      $error("gpio_debounce: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         acc_q <= 1'b0;
      end else if (!en_i) begin
         // track the input so enabling the filter makes no false edge
         cnt_q <= '0;
         acc_q <= d_i;
      end else if (d_i == acc_q) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         acc_q <= d_i;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // bypass when disabled: no added latency
   assign q_o = en_i ? acc_q : d_i;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   input  logic lvl_i,
   input  logic high_i,
   input  logic low_i,
   input  logic ack_i,
   output logic pend_o
);
   logic prev_q;
   logic pend_q;
   logic edge_hit;
   logic lvl_hit;
   logic hit;

   always_comb begin
      edge_hit = (high_i &  d_i & ~prev_q) | (low_i & ~d_i &  prev_q);
      lvl_hit  = (high_i &  d_i)           | (low_i & ~d_i);
      hit      = lvl_i ? lvl_hit : edge_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= d_i;
         // a fresh hit beats an acknowledge in the same cycle
         pend_q <= hit | (pend_q & ~ack_i);
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS           = 32,
   parameter int unsigned NIRQ            = 8,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned DEBOUNCE_CYCLES = 16,
   parameter int unsigned ADDR_W          = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   output logic [31:0]       rd_data,
   input  logic [NPINS-1:0]  pin_i,
   output logic [NPINS-1:0]  pin_o,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq_o
);
   localparam logic [LANE_W-1:0] LANE_MASK = LANE_W'((1 << NIRQ) - 1);
   localparam logic [REG_W-1:0]  CTRL_MASK = {4{LANE_MASK}};

   if (NPINS < 1 || NPINS > REG_W) begin : g_bad_pins
      $error("gpio_port_irq: NPINS must be 1..32");
   end
   if (NIRQ < 1 || NIRQ > LANE_W || NIRQ > NPINS) begin : g_bad_irq
      $error("gpio_port_irq: NIRQ must be 1..8 and not above NPINS");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpio_port_irq: ADDR_W must be at least 6");
   end

   // ---------------- decode ----------------
   logic [3:0] widx;
   logic       w_out_set, w_out_clr, w_dir_out, w_dir_in;
   logic       w_ctl_set, w_ctl_clr, w_ack;

   assign widx      = addr[5:2];
   assign w_out_set = wr_en && (widx == REG_OUT_SET);
   assign w_out_clr = wr_en && (widx == REG_OUT_CLR);
   assign w_dir_out = wr_en && (widx == REG_DIR_OUT);
   assign w_dir_in  = wr_en && (widx == REG_DIR_IN);
   assign w_ctl_set = wr_en && (widx == REG_CTRL_SET);
   assign w_ctl_clr = wr_en && (widx == REG_CTRL_CLR);
   assign w_ack     = wr_en && (widx == REG_ACK);

   // ---------------- state ----------------
   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] out_q;
   logic [REG_W-1:0] ctrl_q;
   trig_ctrl_t       ctrl_v;
   logic [NPINS-1:0] wd_pins;
   logic [REG_W-1:0] ctl_set_v, ctl_clr_v;

   assign wd_pins   = wr_data[NPINS-1:0];
   assign ctl_set_v = w_ctl_set ? wr_data : '0;
   assign ctl_clr_v = w_ctl_clr ? wr_data : '0;
   assign ctrl_v    = ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (w_dir_out) dir_q <= dir_q |  wd_pins;
         if (w_dir_in)  dir_q <= dir_q & ~wd_pins;
         if (w_out_set) out_q <= out_q |  wd_pins;
         if (w_out_clr) out_q <= out_q & ~wd_pins;
         ctrl_q <= ((ctrl_q | ctl_set_v) & ~ctl_clr_v) & CTRL_MASK;
      end
   end

   assign pin_o  = out_q;
   assign pin_oe = dir_q;

   // ---------------- input path ----------------
   logic [NPINS-1:0] pin_s;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   // ---------------- interrupt lanes ----------------
   logic [NIRQ-1:0] filt;
   logic [NIRQ-1:0] pend_q;
   logic [NIRQ-1:0] ack_vec;

   assign ack_vec = w_ack ? wr_data[NIRQ-1:0] : '0;

   for (genvar k = 0; k < NIRQ; k++) begin : g_lane
      gpio_debounce #(.CYCLES(DEBOUNCE_CYCLES)) i_dbnc (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (ctrl_v.dbnc[k]),
         .d_i   (pin_s[k]),
         .q_o   (filt[k])
      );
      gpio_irq_cell i_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_i    (filt[k]),
         .lvl_i  (ctrl_v.lvl[k]),
         .high_i (ctrl_v.high[k]),
         .low_i  (ctrl_v.low[k]),
         .ack_i  (ack_vec[k]),
         .pend_o (pend_q[k])
      );
   end

   assign irq_o = |pend_q;

   // ---------------- read mux ----------------
   logic [3:0] ridx;
   assign ridx = addr[5:2];

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (ridx)
            REG_PIN:  rd_data[NPINS-1:0] = pin_s;
            REG_OUT:  rd_data[NPINS-1:0] = out_q;
            REG_DIR:  rd_data[NPINS-1:0] = dir_q;
            REG_CTRL: rd_data            = ctrl_q;
            REG_STAT: rd_data[NIRQ-1:0]  = pend_q;
            default:  rd_data            = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk #(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned NIRQ   = 8,
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              rd_en,
   input logic [31:0]       rd_data,
   input logic [NPINS-1:0]  pin_o,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq_o,
   input logic [NIRQ-1:0]   pend,
   input logic [NIRQ-1:0]   ack_vec,
   input logic [31:0]       ctrl
);
   logic [NIRQ-1:0] armed;
   assign armed = ctrl[8 +: NIRQ] | ctrl[16 +: NIRQ];

   // R2: direction only moves on a bus write
   a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pin_oe));

   // R3: output latch only moves on a bus write
   a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(pin_o));

   // R8: a pin with neither trigger bit never turns pending
   a_r8_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & ~$past(pend) & ~$past(armed)) == '0));

   // R9: status upper bits read as zero
   a_r9_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr[5:2] == 4'd10) |-> (rd_data[31:NIRQ] == '0));

   // R10: pending bits drop only under acknowledge
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend) & ~$past(ack_vec)) & ~pend) == '0));

   // R14: the combined line can only rise if some pin was armed
   a_r14_irq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(armed) != '0));
endmodule

bind gpio_port_irq gpio_port_irq_chk #(
   .NPINS  (NPINS),
   .NIRQ   (NIRQ),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .rd_data (rd_data),
   .pin_o   (pin_o),
   .pin_oe  (pin_oe),
   .irq_o   (irq_o),
   .pend    (pend_q),
   .ack_vec (ack_vec),
   .ctrl    (ctrl_q)
);

// File: tb/test_gpio_port_irq.sv
`timescale 1ns/1ps
module test_gpio_port_irq;
   localparam int CLK_PERIOD = 10;
   localparam int DB = 16;

   localparam logic [5:0] A_PIN = 6'h00, A_OUT = 6'h04, A_OSET = 6'h08, A_OCLR = 6'h0C,
                          A_DIR = 6'h10, A_DOUT = 6'h14, A_DIN = 6'h18, A_CTRL = 6'h1C,
                          A_CSET = 6'h20, A_CCLR = 6'h24, A_STAT = 6'h28, A_ACK = 6'h2C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [31:0] pin_i = '0;
   logic [31:0] pin_o;
   logic [31:0] pin_oe;
   logic        irq_o;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_irq i_gpio_port_irq (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pin_i(pin_i), .pin_o(pin_o),
      .pin_oe(pin_oe), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic chk_stat(input string req, input logic [31:0] exp);
      logic [31:0] v;
      rd(A_STAT, v);
      check(req, v, exp);
      check({req, " irq"}, {31'd0, irq_o}, {31'd0, exp != 0});
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      check("R1 oe", pin_oe, 32'h0);
      check("R1 out", pin_o, 32'h0);
      rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
      rd(A_DIR, v);  check("R1 dir", v, 32'h0);
      chk_stat("R1 status", 32'h0);

      // R2 direction
      wr(A_DOUT, 32'h0000_FFFF);
      rd(A_DIR, v); check("R2 dir set", v, 32'h0000_FFFF);
      wr(A_DIN, 32'h0000_00F0);
      rd(A_DIR, v); check("R2 dir clr", v, 32'h0000_FF0F);
      check("R2 oe", pin_oe, 32'h0000_FF0F);

      // R3 output latch
      wr(A_OSET, 32'h1234_5678);
      wr(A_OCLR, 32'h0000_0078);
      rd(A_OUT, v); check("R3 out", v, 32'h1234_5600);
      check("R3 pins", pin_o, 32'h1234_5600);

      // R4 synchronizer latency
      pin_i = 32'hA5A5_5A5A;
      @(negedge clk); rd(A_PIN, v); check("R4 one edge", v, 32'h0);
      @(negedge clk); rd(A_PIN, v); check("R4 two edges", v, 32'hA5A5_5A5A);
      pin_i = '0; idle(3);

      // R5 control word set/clear/readback
      wr(A_CSET, 32'hFFFF_FFFF);
      rd(A_CTRL, v); check("R5 ctrl set", v, 32'hFFFF_FFFF);
      wr(A_CCLR, 32'h0F0F_0F0F);
      rd(A_CTRL, v); check("R5 ctrl clr", v, 32'hF0F0_F0F0);
      wr(A_CCLR, 32'hFFFF_FFFF);
      idle(4); wr(A_ACK, 32'hFF); idle(2);

      // R6 R7 R9 R10 R11 sweep: modes 0 rise,1 fall,2 both,3 high,4 low
      for (int p = 0; p < 8; p++) begin
         for (int m = 0; m < 5; m++) begin
            logic [31:0] bit_p, hp, ctl;
            bit r, f, b, h, l;
            r = (m == 0); f = (m == 1); b = (m == 2); h = (m == 3); l = (m == 4);
            bit_p = 32'h1 << p;
            hp = (32'h0101_0100) << p;   // pins 8+p,16+p,24+p: cannot interrupt (R9)
            ctl = ((h || l) ? bit_p : 32'h0)
                | ((r || b || h) ? (bit_p << 8) : 32'h0)
                | ((f || b || l) ? (bit_p << 16) : 32'h0);
            wr(A_CCLR, 32'hFFFF_FFFF);
            pin_i = '0; idle(4);
            wr(A_ACK, 32'hFF);
            wr(A_CSET, ctl);
            idle(2);
            chk_stat("R7 low level at config", l ? bit_p : 32'h0);
            wr(A_ACK, 32'hFF); idle(1);
            chk_stat("R11 low level after ack", l ? bit_p : 32'h0);
            pin_i = bit_p | hp; idle(5);
            chk_stat("R6 R7 R9 after rise", (r || b || h || l) ? bit_p : 32'h0);
            wr(A_ACK, 32'hFF); idle(2);
            chk_stat("R10 R11 after ack high", h ? bit_p : 32'h0);
            pin_i = '0; idle(5);
            chk_stat("R6 R7 after fall", r ? 32'h0 : bit_p);
            wr(A_ACK, 32'hFF); idle(2);
            chk_stat("R10 R11 after ack low", l ? bit_p : 32'h0);
         end
      end

      // R8 masked pin: level select only, pin toggles
      wr(A_CCLR, 32'hFFFF_FFFF);
      wr(A_ACK, 32'hFF);
      wr(A_CSET, 32'h0000_0008);
      pin_i = 32'h8; idle(5); pin_i = 32'h0; idle(5);
      chk_stat("R8 masked", 32'h0);

      // R12 edge and acknowledge in the same cycle; R10 one cycle later clears
      wr(A_CCLR, 32'hFFFF_FFFF);
      wr(A_CSET, 32'h0000_0100);
      idle(3); wr(A_ACK, 32'hFF);
      pin_i = 32'h1; idle(2);
      wr(A_ACK, 32'h1);            // sampled on the edge that sets pending
      idle(1);
      chk_stat("R12 edge wins", 32'h1);
      pin_i = 32'h0; idle(4); wr(A_ACK, 32'hFF); idle(1);
      pin_i = 32'h1; idle(3);
      wr(A_ACK, 32'h1);            // one cycle after pending set
      idle(1);
      chk_stat("R10 late ack clears", 32'h0);

      // R13 debounce on pin 0, rising
      pin_i = 32'h0;
      wr(A_CCLR, 32'hFFFF_FFFF);
      wr(A_CSET, 32'h0100_0100);
      idle(4); wr(A_ACK, 32'hFF);
      pin_i = 32'h1; idle(DB - 6); pin_i = 32'h0; idle(3 * DB);
      chk_stat("R13 short pulse ignored", 32'h0);
      pin_i = 32'h1; idle(DB + 6);
      chk_stat("R13 stable change accepted", 32'h1);
      wr(A_ACK, 32'hFF); idle(1);
      chk_stat("R14 irq low after ack", 32'h0);

      done = 1;
      summary();
      $finish;
   end
endmodule